// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block carries out the state changes that happen when a hart takes a trap or runs a machine-level or supervisor-level return. Each clock it samples one event command. A trap entry captures the cause, the faulting PC and the trap value into the register set of the target privilege. It saves the old interrupt enable and the old privilege, disables interrupts at that level and selects the handler address from that level's trap-vector register. A return restores the interrupt enable from its saved copy and drops to the saved privilege. It then issues the saved exception PC, aligned to the instruction granularity currently in force.

The decision about which privilege handles a trap is made elsewhere and arrives on `del_priv`. All outputs are registered, so every effect of an event is visible in the cycle after it is sampled. Every trap and every return also gives a one-cycle pulse that clears any load-reserved reservation. A trap vector with a mode the block does not support raises an error pulse and produces no target.

Top module: `trap_sequencer`

## Requirements
- R1: After reset the privilege is machine (code 3), all seven status bits are 0, the cause, epc and tval registers are 0, `next_pc` is 0, and `next_pc_vld`, `vec_err` and `rsv_cancel` are low.
- R2: `evt_kind` encodes 0 = idle, 1 = trap, 2 = machine return, 3 = supervisor return. Every non-idle event gives `rsv_cancel` high for exactly the following cycle. An idle cycle gives no pulse and changes no register.
- R3: A trap with `del_priv` = 3 sets `mcause` to the interrupt flag in bit XLEN-1 with the code in the low CAUSE_W bits and zeros between. It also sets `mepc` to `evt_pc` and `mtval` to `evt_tval` when `evt_tval_vld` is 1, otherwise 0. The saved enable `st_mpie` takes the old `st_mie`, `st_mie` clears, `st_mpp` takes the old privilege and the privilege becomes 3. No supervisor register changes.
- R4: A trap with any other `del_priv` writes `scause`, `sepc` and `stval` in the same way. The saved enable `st_spie` takes the old `st_sie`, `st_sie` clears, `st_spp` becomes 1 only if the old privilege was supervisor (code 1), and the privilege becomes 1. No machine register changes.
- R5: The vector mode is bits 1:0 of the selected vector register, and the base is that register with bits 1:0 cleared. In mode 0 the target is the base. In mode 1 an interrupt jumps to base + 4 × code and an exception jumps to the base. The target appears on `next_pc` with `next_pc_vld` high for one cycle.
- R6: Vector modes 2 and 3 give a one-cycle `vec_err` pulse with `next_pc_vld` low and `next_pc` unchanged, while the cause, epc, tval, status and privilege updates of R3 or R4 still take place.
- R7: A machine return copies `st_mpie` into `st_mie`, sets `st_mpie` to 1, sets the privilege to `st_mpp`, and issues the masked `mepc` on `next_pc` with `next_pc_vld` high.
- R8: A supervisor return copies `st_spie` into `st_sie` and sets `st_spie` to 1. It sets the privilege to 1 when `st_spp` is 1 and to 0 otherwise, and issues the masked `sepc` on `next_pc` with `next_pc_vld` high.
- R9: The return mask always clears bit 0 and also clears bit 1 when `c_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_kind | input | 2 | Event command: idle, trap, machine return, supervisor return |
| evt_intr | input | 1 | Trap is an interrupt |
| evt_code | input | CAUSE_W | Trap cause code |
| evt_pc | input | XLEN | PC of the trapping instruction |
| evt_tval_vld | input | 1 | Trap value is supplied |
| evt_tval | input | XLEN | Trap value |
| del_priv | input | 2 | Handling privilege chosen by the delegation logic |
| mtvec | input | XLEN | Machine trap-vector register |
| stvec | input | XLEN | Supervisor trap-vector register |
| c_en | input | 1 | Compressed instructions enabled |
| priv | output | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| st_mie | output | 1 | Machine interrupt enable |
| st_mpie | output | 1 | Saved machine interrupt enable |
| st_mpp | output | 2 | Saved privilege for machine return |
| st_sie | output | 1 | Supervisor interrupt enable |
| st_spie | output | 1 | Saved supervisor interrupt enable |
| st_spp | output | 1 | Saved privilege for supervisor return |
| mcause | output | XLEN | Machine cause register |
| scause | output | XLEN | Supervisor cause register |
| mepc | output | XLEN | Machine exception PC |
| sepc | output | XLEN | Supervisor exception PC |
| mtval | output | XLEN | Machine trap value |
| stval | output | XLEN | Supervisor trap value |
| next_pc | output | XLEN | Redirect target |
| next_pc_vld | output | 1 | One-cycle strobe: `next_pc` is a new target |
| vec_err | output | 1 | One-cycle strobe: unsupported vector mode |
| rsv_cancel | output | 1 | One-cycle strobe: clear the load reservation |

## Verification
Directed traps walk each vector mode for both an interrupt and an exception. This separates the direct base, the scaled vectored offset and the ignored offset for exceptions, and it shows that modes 2 and 3 give an error and no target. Nested machine and supervisor traps followed by both returns, taken from machine, supervisor and user privilege, show whether the saved-enable and saved-privilege fields are swapped, cleared or restored in the right order. Running the same returns with `c_en` high and low separates the two alignment masks. A long random mix of idle cycles, events, delegation targets, trap-value presence and vector modes then checks every output each cycle against a reference model kept in the bench.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_TRAP = 2'd1,
      EV_MRET = 2'd2,
      EV_SRET = 2'd3
   } ev_e;

   localparam logic [1:0] PRV_U = 2'd0;
   localparam logic [1:0] PRV_S = 2'd1;
   localparam logic [1:0] PRV_M = 2'd3;

   typedef struct packed {
      logic       mie;
      logic       mpie;
      logic [1:0] mpp;
      logic       sie;
      logic       spie;
      logic       spp;
   } stat_t;

endpackage

// File: rtl/trap_vec_target.sv
// Handler address from a trap-vector register; flags unsupported modes.
module trap_vec_target #(
   parameter int XLEN        = 64,
   parameter int CAUSE_W     = 6,
   parameter bit VECTORED_EN = 1'b1
) (
   input  logic [XLEN-1:0]    tvec,
   input  logic               intr,
   input  logic [CAUSE_W-1:0] code,
   output logic [XLEN-1:0]    target,
   output logic               bad
);
   localparam int PAD_W = XLEN - CAUSE_W;

   logic [XLEN-1:0] base;
   logic [XLEN-1:0] offset;
   logic [1:0]      mode;

   assign base   = tvec & {{(XLEN-2){1'b1}}, 2'b00};
   assign mode   = tvec[1:0];
   assign offset = {{PAD_W{1'b0}}, code} << 2;

   generate
      if (VECTORED_EN) begin : g_vectored
         always_comb begin
            target = base;
            bad    = 1'b0;
            unique case (mode)
               2'd0:    target = base;
               2'd1:    target = intr ? (base + offset) : base;
               default: bad = 1'b1;
            endcase
         end
      end else begin : g_direct_only
         always_comb begin
            target = base;
            bad    = (mode != 2'd0);
         end
      end
   endgenerate
endmodule

// File: rtl/ret_pc_mask.sv
// Aligns a saved exception PC to the current instruction granularity.
module ret_pc_mask #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] epc,
   input  logic            c_en,
   output logic [XLEN-1:0] pc_out
);
   assign pc_out = epc & {{(XLEN-2){1'b1}}, c_en, 1'b0};
endmodule

// File: rtl/trap_status_next.sv
// Next privilege and status fields for a given event.
module trap_status_next
   import trap_seq_pkg::*;
(
   input  ev_e        ev,
   input  logic       del_m,
   input  logic [1:0] priv_cur,
   input  stat_t      st_cur,
   output stat_t      st_nxt,
   output logic [1:0] priv_nxt
);
   always_comb begin
      st_nxt   = st_cur;
      priv_nxt = priv_cur;
      unique case (ev)
         EV_TRAP: begin
            if (del_m) begin
               st_nxt.mpie = st_cur.mie;
               st_nxt.mie  = 1'b0;
               st_nxt.mpp  = priv_cur;
               priv_nxt    = PRV_M;
            end else begin
               st_nxt.spie = st_cur.sie;
               st_nxt.sie  = 1'b0;
               st_nxt.spp  = (priv_cur == PRV_S);
               priv_nxt    = PRV_S;
            end
         end
         EV_MRET: begin
            st_nxt.mie  = st_cur.mpie;
            st_nxt.mpie = 1'b1;
            priv_nxt    = st_cur.mpp;
         end
         EV_SRET: begin
            st_nxt.sie  = st_cur.spie;
            st_nxt.spie = 1'b1;
            priv_nxt    = st_cur.spp ? PRV_S : PRV_U;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
   import trap_seq_pkg::*;
#(
   parameter int XLEN        = 64,
   parameter int CAUSE_W     = 6,
   parameter bit VECTORED_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         evt_kind,
   input  logic               evt_intr,
   input  logic [CAUSE_W-1:0] evt_code,
   input  logic [XLEN-1:0]    evt_pc,
   input  logic               evt_tval_vld,
   input  logic [XLEN-1:0]    evt_tval,
   input  logic [1:0]         del_priv,
   input  logic [XLEN-1:0]    mtvec,
   input  logic [XLEN-1:0]    stvec,
   input  logic               c_en,
   output logic [1:0]         priv,
   output logic               st_mie,
   output logic               st_mpie,
   output logic [1:0]         st_mpp,
   output logic               st_sie,
   output logic               st_spie,
   output logic               st_spp,
   output logic [XLEN-1:0]    mcause,
   output logic [XLEN-1:0]    scause,
   output logic [XLEN-1:0]    mepc,
   output logic [XLEN-1:0]    sepc,
   output logic [XLEN-1:0]    mtval,
   output logic [XLEN-1:0]    stval,
   output logic [XLEN-1:0]    next_pc,
   output logic               next_pc_vld,
   output logic               vec_err,
   output logic               rsv_cancel
);
   localparam int GAP_W = XLEN - 1 - CAUSE_W;
   localparam int N_LVL = 2;   // index 0 machine, 1 supervisor

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_chk_xlen
         $error("trap_sequencer: XLEN must be 32 or 64");
      end
      if (CAUSE_W < 1 || GAP_W < 0) begin : g_chk_cause
         $error("trap_sequencer: CAUSE_W must fit below the interrupt bit");
      end
   endgenerate

   ev_e        ev;
   logic       del_m;
   stat_t      st_q, st_d;
   logic [1:0] priv_q, priv_d;

   assign ev    = ev_e'(evt_kind);
   assign del_m = (del_priv == PRV_M);

   trap_status_next u_status (
      .ev       (ev),
      .del_m    (del_m),
      .priv_cur (priv_q),
      .st_cur   (st_q),
      .st_nxt   (st_d),
      .priv_nxt (priv_d)
   );

   // Per-level vector and return-address logic
   logic [N_LVL-1:0][XLEN-1:0] tvec_a, tgt_a, epc_a, ret_a;
   logic [N_LVL-1:0]           bad_a;

   logic [XLEN-1:0] mepc_q, sepc_q;
   assign tvec_a[0] = mtvec;
   assign tvec_a[1] = stvec;
   assign epc_a[0]  = mepc_q;
   assign epc_a[1]  = sepc_q;

   generate
      for (genvar gi = 0; gi < N_LVL; gi++) begin : g_lvl
         trap_vec_target #(
            .XLEN        (XLEN),
            .CAUSE_W     (CAUSE_W),
            .VECTORED_EN (VECTORED_EN)
         ) u_vec (
            .tvec   (tvec_a[gi]),
            .intr   (evt_intr),
            .code   (evt_code),
            .target (tgt_a[gi]),
            .bad    (bad_a[gi])
         );
         ret_pc_mask #(.XLEN(XLEN)) u_ret (
            .epc    (epc_a[gi]),
            .c_en   (c_en),
            .pc_out (ret_a[gi])
         );
      end
   endgenerate

   logic [XLEN-1:0] cause_val, tval_val;
   assign cause_val = {evt_intr, {GAP_W{1'b0}}, evt_code};
   assign tval_val  = evt_tval_vld ? evt_tval : '0;

   logic [XLEN-1:0] mcause_q, scause_q, mtval_q, stval_q, npc_q;
   logic            vld_q, err_q, cancel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         priv_q   <= PRV_M;
         st_q     <= '0;
         mcause_q <= '0;
         scause_q <= '0;
         mepc_q   <= '0;
         sepc_q   <= '0;
         mtval_q  <= '0;
         stval_q  <= '0;
         npc_q    <= '0;
         vld_q    <= 1'b0;
         err_q    <= 1'b0;
         cancel_q <= 1'b0;
      end else begin
         priv_q   <= priv_d;
         st_q     <= st_d;
         cancel_q <= (ev != EV_NONE);
         vld_q    <= 1'b0;
         err_q    <= 1'b0;
         unique case (ev)
            EV_TRAP: begin
               if (del_m) begin
                  mcause_q <= cause_val;
                  mepc_q   <= evt_pc;
                  mtval_q  <= tval_val;
                  if (!bad_a[0]) npc_q <= tgt_a[0];
                  vld_q    <= !bad_a[0];
                  err_q    <= bad_a[0];
               end else begin
                  scause_q <= cause_val;
                  sepc_q   <= evt_pc;
                  stval_q  <= tval_val;
                  if (!bad_a[1]) npc_q <= tgt_a[1];
                  vld_q    <= !bad_a[1];
                  err_q    <= bad_a[1];
               end
            end
            EV_MRET: begin
               npc_q <= ret_a[0];
               vld_q <= 1'b1;
            end
            EV_SRET: begin
               npc_q <= ret_a[1];
               vld_q <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign priv        = priv_q;
   assign st_mie      = st_q.mie;
   assign st_mpie     = st_q.mpie;
   assign st_mpp      = st_q.mpp;
   assign st_sie      = st_q.sie;
   assign st_spie     = st_q.spie;
   assign st_spp      = st_q.spp;
   assign mcause      = mcause_q;
   assign scause      = scause_q;
   assign mepc        = mepc_q;
   assign sepc        = sepc_q;
   assign mtval       = mtval_q;
   assign stval       = stval_q;
   assign next_pc     = npc_q;
   assign next_pc_vld = vld_q;
   assign vec_err     = err_q;
   assign rsv_cancel  = cancel_q;
endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      evt_kind,
   input logic [XLEN-1:0] evt_pc,
   input logic [1:0]      del_priv,
   input logic [1:0]      priv,
   input logic            st_mie,
   input logic            st_mpie,
   input logic [1:0]      st_mpp,
   input logic            st_sie,
   input logic            st_spie,
   input logic            st_spp,
   input logic [XLEN-1:0] mepc,
   input logic [XLEN-1:0] sepc,
   input logic [XLEN-1:0] next_pc,
   input logic            next_pc_vld,
   input logic            vec_err,
   input logic            rsv_cancel
);
   p_cancel_on_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_kind != 2'd0) |=> rsv_cancel);

   p_no_cancel_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_kind == 2'd0) |=> !rsv_cancel);

   p_mtrap_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_kind == 2'd1 && del_priv == 2'd3) |=>
         (priv == 2'd3 && !st_mie && st_mpie == $past(st_mie) &&
          st_mpp == $past(priv) && mepc == $past(evt_pc)));

   p_strap_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_kind == 2'd1 && del_priv != 2'd3) |=>
         (priv == 2'd1 && !st_sie && st_spie == $past(st_sie) &&
          sepc == $past(evt_pc)));

   p_target_or_error_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(next_pc_vld && vec_err));

   p_mret_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_kind == 2'd2) |=>
         (priv == $past(st_mpp) && st_mpie && st_mie == $past(st_mpie) && next_pc_vld));

   p_sret_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_kind == 2'd3) |=>
         (priv == ($past(st_spp) ? 2'd1 : 2'd0) && st_spie &&
          st_sie == $past(st_spie) && next_pc_vld));

   p_ret_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_kind[1]) |=> !next_pc[0]);
endmodule

bind trap_sequencer trap_sequencer_chk #(.XLEN(XLEN)) u_trap_sequencer_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_kind    (evt_kind),
   .evt_pc      (evt_pc),
   .del_priv    (del_priv),
   .priv        (priv),
   .st_mie      (st_mie),
   .st_mpie     (st_mpie),
   .st_mpp      (st_mpp),
   .st_sie      (st_sie),
   .st_spie     (st_spie),
   .st_spp      (st_spp),
   .mepc        (mepc),
   .sepc        (sepc),
   .next_pc     (next_pc),
   .next_pc_vld (next_pc_vld),
   .vec_err     (vec_err),
   .rsv_cancel  (rsv_cancel)
);

// File: tb/test_trap_sequencer.sv
`timescale 1ns/1ps
module test_trap_sequencer;
   localparam int XLEN    = 64;
   localparam int CAUSE_W = 6;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [1:0]         evt_kind = '0;
   logic               evt_intr = 1'b0;
   logic [CAUSE_W-1:0] evt_code = '0;
   logic [XLEN-1:0]    evt_pc = '0;
   logic               evt_tval_vld = 1'b0;
   logic [XLEN-1:0]    evt_tval = '0;
   logic [1:0]         del_priv = '0;
   logic [XLEN-1:0]    mtvec = '0;
   logic [XLEN-1:0]    stvec = '0;
   logic               c_en = 1'b0;

   logic [1:0]      priv;
   logic            st_mie, st_mpie, st_sie, st_spie, st_spp;
   logic [1:0]      st_mpp;
   logic [XLEN-1:0] mcause, scause, mepc, sepc, mtval, stval, next_pc;
   logic            next_pc_vld, vec_err, rsv_cancel;

   always #2 clk = ~clk;

   trap_sequencer #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) i_trap_sequencer (
      .clk, .rst_n, .evt_kind, .evt_intr, .evt_code, .evt_pc, .evt_tval_vld,
      .evt_tval, .del_priv, .mtvec, .stvec, .c_en, .priv, .st_mie, .st_mpie,
      .st_mpp, .st_sie, .st_spie, .st_spp, .mcause, .scause, .mepc, .sepc,
      .mtval, .stval, .next_pc, .next_pc_vld, .vec_err, .rsv_cancel
   );

   int n_chk = 0;
   int n_bad = 0;

   // reference model state
   logic [1:0]      m_priv;
   logic            m_mie, m_mpie, m_sie, m_spie, m_spp;
   logic [1:0]      m_mpp;
   logic [XLEN-1:0] m_mcause, m_scause, m_mepc, m_sepc, m_mtval, m_stval, m_npc;
   logic            m_vld, m_err, m_cancel;

   function automatic logic vec_bad(input logic [XLEN-1:0] tv);
      return tv[1:0] > 2'd1;
   endfunction

   function automatic logic [XLEN-1:0] vec_tgt(input logic [XLEN-1:0] tv,
                                               input logic intr,
                                               input logic [CAUSE_W-1:0] code);
      logic [XLEN-1:0] b;
      b = {tv[XLEN-1:2], 2'b00};
      if (tv[1:0] == 2'd1 && intr) return b + 64'(code) * 4;
      return b;
   endfunction

   function automatic logic [XLEN-1:0] ret_mask(input logic [XLEN-1:0] e, input logic c);
      logic [XLEN-1:0] r;
      r = e;
      r[0] = 1'b0;
      if (!c) r[1] = 1'b0;
      return r;
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, "priv", 64'(priv), 64'(m_priv));
      chk(tag, "status", 64'({st_mie, st_mpie, st_mpp, st_sie, st_spie, st_spp}),
          64'({m_mie, m_mpie, m_mpp, m_sie, m_spie, m_spp}));
      chk(tag, "mcause", mcause, m_mcause);
      chk(tag, "scause", scause, m_scause);
      chk(tag, "mepc", mepc, m_mepc);
      chk(tag, "sepc", sepc, m_sepc);
      chk(tag, "mtval", mtval, m_mtval);
      chk(tag, "stval", stval, m_stval);
      chk(tag, "next_pc", next_pc, m_npc);
      chk(tag, "strobes", 64'({next_pc_vld, vec_err, rsv_cancel}),
          64'({m_vld, m_err, m_cancel}));
   endtask

   task automatic model_step();
      logic [XLEN-1:0] cz, tv;
      logic            bad;
      m_vld = 1'b0; m_err = 1'b0;
      m_cancel = (evt_kind != 2'd0);
      cz = '0;
      cz[XLEN-1] = evt_intr;
      cz[CAUSE_W-1:0] = evt_code;
      case (evt_kind)
         2'd1: begin
            if (del_priv == 2'd3) begin
               m_mcause = cz; m_mepc = evt_pc;
               m_mtval = evt_tval_vld ? evt_tval : '0;
               m_mpie = m_mie; m_mie = 1'b0; m_mpp = m_priv; m_priv = 2'd3;
               tv = mtvec;
            end else begin
               m_scause = cz; m_sepc = evt_pc;
               m_stval = evt_tval_vld ? evt_tval : '0;
               m_spie = m_sie; m_sie = 1'b0; m_spp = (m_priv == 2'd1); m_priv = 2'd1;
               tv = stvec;
            end
            bad = vec_bad(tv);
            m_err = bad; m_vld = !bad;
            if (!bad) m_npc = vec_tgt(tv, evt_intr, evt_code);
         end
         2'd2: begin
            m_mie = m_mpie; m_mpie = 1'b1; m_priv = m_mpp;
            m_npc = ret_mask(m_mepc, c_en); m_vld = 1'b1;
         end
         2'd3: begin
            m_sie = m_spie; m_spie = 1'b1; m_priv = m_spp ? 2'd1 : 2'd0;
            m_npc = ret_mask(m_sepc, c_en); m_vld = 1'b1;
         end
         default: ;
      endcase
   endtask

   // drive at negedge, one cycle, check at next negedge
   task automatic step(input string tag, input logic [1:0] k, input logic intr,
                       input logic [CAUSE_W-1:0] code, input logic [XLEN-1:0] pc,
                       input logic tvv, input logic [XLEN-1:0] tv, input logic [1:0] dp,
                       input logic [XLEN-1:0] mt, input logic [XLEN-1:0] stv, input logic c);
      evt_kind = k; evt_intr = intr; evt_code = code; evt_pc = pc;
      evt_tval_vld = tvv; evt_tval = tv; del_priv = dp;
      mtvec = mt; stvec = stv; c_en = c;
      @(posedge clk);
      model_step();
      @(negedge clk);
      check_all(tag);
   endtask

   task automatic idle(input string tag);
      step(tag, 2'd0, 1'b0, '0, '0, 1'b0, '0, 2'd0, mtvec, stvec, c_en);
   endtask

   logic done = 1'b0;

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      m_priv = 2'd3; {m_mie, m_mpie, m_mpp, m_sie, m_spie, m_spp} = '0;
      m_mcause = '0; m_scause = '0; m_mepc = '0; m_sepc = '0;
      m_mtval = '0; m_stval = '0; m_npc = '0;
      m_vld = 0; m_err = 0; m_cancel = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 reset");
      idle("R2 idle");

      // R3 machine trap, direct mode, exception with tval
      step("R3 m-trap direct", 2'd1, 1'b0, 6'd2, 64'h8000_1236, 1'b1, 64'hdead,
           2'd3, 64'h8000_0100, 64'h4000_0200, 1'b1);
      // R5 vectored interrupt code 5 -> base+20 (M again, from M)
      step("R5 m-trap vectored intr", 2'd1, 1'b1, 6'd5, 64'h8000_2000, 1'b0, 64'h1,
           2'd3, 64'h8000_0101, 64'h4000_0200, 1'b1);
      // R5 vectored exception -> base
      step("R5 m-trap vectored exc", 2'd1, 1'b0, 6'd7, 64'h8000_3000, 1'b0, 64'h0,
           2'd3, 64'h8000_0301, 64'h4000_0200, 1'b1);
      // R7 mret with c_en=0: mepc 0x8000_3000 stays; then R9 with odd epc
      step("R7 mret", 2'd2, 1'b0, '0, '0, 1'b0, '0, 2'd0, 64'h8000_0301, 64'h4000_0200, 1'b0);
      // R4 supervisor trap from M, vectored interrupt
      step("R4 s-trap", 2'd1, 1'b1, 6'd9, 64'h1234_5677, 1'b1, 64'hbeef,
           2'd1, 64'h8000_0100, 64'h4000_0201, 1'b1);
      // R4 nested supervisor trap from S
      step("R4 s-trap nested", 2'd1, 1'b0, 6'd13, 64'h1234_0003, 1'b0, 64'h55,
           2'd1, 64'h8000_0100, 64'h4000_0200, 1'b1);
      // R9/R8 sret with c_en=1 then c_en=0 on the same sepc
      step("R8 sret c_en=1 R9", 2'd3, 1'b0, '0, '0, 1'b0, '0, 2'd0, 64'h8000_0100, 64'h4000_0200, 1'b1);
      step("R8 sret c_en=0 R9", 2'd3, 1'b0, '0, '0, 1'b0, '0, 2'd0, 64'h8000_0100, 64'h4000_0200, 1'b0);
      // R6 invalid modes 2 and 3
      step("R6 m-trap mode2", 2'd1, 1'b1, 6'd3, 64'h9000_0000, 1'b1, 64'h77,
           2'd3, 64'h8000_0102, 64'h4000_0200, 1'b1);
      step("R6 s-trap mode3", 2'd1, 1'b0, 6'd1, 64'h9000_0010, 1'b0, 64'h0,
           2'd0, 64'h8000_0100, 64'h4000_0203, 1'b1);
      idle("R2 idle after error");

      for (int i = 0; i < 1500; i++) begin
         logic [1:0] k, dp;
         logic [XLEN-1:0] mt, stv;
         int r;
         r = $urandom % 8;
         k = (r < 2) ? 2'd0 : (r < 5) ? 2'd1 : (r < 7) ? 2'd2 : 2'd3;
         dp = 2'($urandom);
         mt = {$urandom, $urandom};
         stv = {$urandom, $urandom};
         r = $urandom % 8;
         mt[1:0] = (r < 3) ? 2'd0 : (r < 6) ? 2'd1 : 2'(r - 4);
         r = $urandom % 8;
         stv[1:0] = (r < 3) ? 2'd0 : (r < 6) ? 2'd1 : 2'(r - 4);
         step("R2 R3 R4 R5 R6 R7 R8 R9 random", k, 1'($urandom), 6'($urandom),
              {$urandom, $urandom}, 1'($urandom), {$urandom, $urandom}, dp,
              mt, stv, 1'($urandom));
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule